// File: doc/BRIEF.md
# Register-Amount Barrel Shifter with Carry

This block is a purely combinational 32-bit shifter. The shift distance comes from a register operand, so it can be anything from 0 to 255. It offers four operations: logical left, logical right, arithmetic right and rotate right. Alongside the shifted word it produces a carry bit that follows exact rules for zero distances, a distance equal to the word width, and distances past the width.

An execute stage places it in front of the flag logic. The stage feeds in the data word, the full amount register, the operation code and the current carry flag, and takes back the result and the candidate carry. Writing the flags back is left to the surrounding pipeline.

A single right-shifting log-stage network does all four operations. A left shift is done by reversing the bits on the way in and on the way out. One extra guard bit below the data captures the last bit shifted out.

Top module: `regshift_carry`

## Requirements
- R1: Only bits 7:0 of `amount_in` set the distance n. Changing bits 31:8 has no effect on either output.
- R2: When n = 0, `result_out` equals `data_in` and `carry_out` equals `carry_in` for every `shift_kind`.
- R3: For logical left (`shift_kind` = 2'b00) with 1 ≤ n ≤ 31, the result is `data_in << n` and the carry is `data_in[32-n]`.
- R4: For logical left with n = 32, the result is 0 and the carry is `data_in[0]`. With n > 32, the result and the carry are both 0.
- R5: For logical right (`shift_kind` = 2'b01) with 1 ≤ n ≤ 31, the result is `data_in >> n` with zero fill and the carry is `data_in[n-1]`.
- R6: For logical right with n = 32, the result is 0 and the carry is `data_in[31]`. With n > 32, the result and the carry are both 0.
- R7: For arithmetic right (`shift_kind` = 2'b10) with 1 ≤ n ≤ 31, the result is `data_in` shifted right with sign fill and the carry is `data_in[n-1]`.
- R8: For arithmetic right with n ≥ 32, every result bit equals `data_in[31]` and the carry is `data_in[31]`.
- R9: For rotate right (`shift_kind` = 2'b11), let m = n mod 32. When m ≠ 0, the result is `data_in` rotated right by m and the carry is `data_in[m-1]`.
- R10: For rotate right with n ≠ 0 and m = 0 (n = 32, 64, …, 224), the result equals `data_in` and the carry is `data_in[31]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_in | input | 32 | Word to be shifted |
| amount_in | input | 32 | Amount register; only the low byte is the distance |
| shift_kind | input | 2 | 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right |
| carry_in | input | 1 | Current carry flag, passed through when unchanged |
| result_out | output | 32 | Shifted word |
| carry_out | output | 1 | New carry value |

## Verification
The hardest cases are at the width boundary: distance 32 against 33 and above for the logical shifts, and rotates by nonzero multiples of 32. A sweep of random amounts would rarely hit these distances.

The bench therefore walks every one of the 256 low-byte distances for each operation. It applies them to corner words that separate bit 0 from bit 31 and the sign from the rest, plus random words. It toggles the incoming carry so that a wrongly passed-through carry shows up. A separate pass fills the ignored upper amount bits with random values.

// File: rtl/shc_pkg.sv
// Shared types for the register-amount shifter.
// Assumes a two-bit operation code; encodings are fixed by R3..R10.
package shc_pkg;

    typedef enum logic [1:0] {
        SHK_LSL = 2'b00,
        SHK_LSR = 2'b01,
        SHK_ASR = 2'b10,
        SHK_ROR = 2'b11
    } shift_kind_e;

    // Classification of the 8-bit distance relative to the word width.
    typedef struct packed {
        logic is_zero;   // distance is 0
        logic in_range;  // 1 .. W-1
        logic is_full;   // exactly W
        logic beyond;    // more than W
        logic rot_wrap;  // nonzero, but a multiple of W
    } amt_class_t;

endpackage

// File: rtl/shc_amt_decode.sv
// Classifies the shift distance against the word width.
// Assumes W is a power of two and fits in AMT_W bits.
module shc_amt_decode
    import shc_pkg::*;
#(
    parameter int W     = 32,
    parameter int AMT_W = 8,
    localparam int SW   = $clog2(W)
) (
    input  logic [AMT_W-1:0] amt,
    output amt_class_t       cls
);

    localparam logic [AMT_W-1:0] W_AMT = AMT_W'(W);

    // Compare the distance against zero and the width boundary.
    always_comb begin
        cls.is_zero  = (amt == '0);
        cls.in_range = (amt != '0) && (amt < W_AMT);
        cls.is_full  = (amt == W_AMT);
        cls.beyond   = (amt > W_AMT);
        cls.rot_wrap = (amt[SW-1:0] == '0) && (amt != '0);
    end

endmodule

// File: rtl/shc_barrel.sv
// Log-stage right shifter/rotator with a guard bit that captures the
// last bit shifted out. In rotate mode the guard stays 0.
// Assumes W is a power of two.
module shc_barrel #(
    parameter int W   = 32,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  data,
    input  logic [SW-1:0] amt,
    input  logic          rotate,
    input  logic          fill,
    output logic [W-1:0]  result,
    output logic          last_out
);

    logic [W:0] stg [0:SW];

    assign stg[0] = {data, 1'b0};

    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int S = 1 << k;
        // One stage: move right by 2**k when that distance bit is set.
        assign stg[k+1] = !amt[k] ? stg[k] :
                          rotate  ? {stg[k][S:1], stg[k][W:S+1], 1'b0} :
                                    {{S{fill}}, stg[k][W:S]};
    end

    assign result   = stg[SW][W:1];
    assign last_out = stg[SW][0];

endmodule

// File: rtl/shc_select.sv
// Picks the final word and carry from the barrel output and the
// distance class, applying the boundary rules of each operation.
module shc_select
    import shc_pkg::*;
#(
    parameter int W = 32
) (
    input  shift_kind_e     kind,
    input  amt_class_t      cls,
    input  logic [W-1:0]    data,
    input  logic            cin,
    input  logic [W-1:0]    sh_res,
    input  logic            sh_carry,
    output logic [W-1:0]    res,
    output logic            cout
);

    // Boundary and pass-through selection per operation.
    always_comb begin
        res  = sh_res;
        cout = sh_carry;
        if (cls.is_zero) begin
            res  = data;
            cout = cin;
        end else begin
            unique case (kind)
                SHK_LSL, SHK_LSR: begin
                    if (cls.is_full) begin
                        res  = '0;
                        cout = (kind == SHK_LSL) ? data[0] : data[W-1];
                    end else if (cls.beyond) begin
                        res  = '0;
                        cout = 1'b0;
                    end
                end
                SHK_ASR: begin
                    if (!cls.in_range) begin
                        res  = {W{data[W-1]}};
                        cout = data[W-1];
                    end
                end
                SHK_ROR: begin
                    if (cls.rot_wrap) begin
                        res  = data;
                        cout = data[W-1];
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/regshift_carry.sv
// Combinational shifter with register-specified distance and carry out.
// Left shifts reuse the right barrel through bit reversal.
// Assumes only the low AMT_W bits of the amount register are meaningful.
module regshift_carry
    import shc_pkg::*;
#(
    parameter int W      = 32,
    parameter int AREG_W = 32,
    parameter int AMT_W  = 8,
    localparam int SW    = $clog2(W)
) (
    input  logic [W-1:0]      data_in,
    input  logic [AREG_W-1:0] amount_in,
    input  logic [1:0]        shift_kind,
    input  logic              carry_in,
    output logic [W-1:0]      result_out,
    output logic              carry_out
);

    shift_kind_e       kind;
    amt_class_t        cls;
    logic [AMT_W-1:0]  amt;
    logic [W-1:0]      rev_d, b_in, b_res, rev_res, sh_res;
    logic              b_last, sh_carry, is_left;
    logic              unused_hi;

    assign kind      = shift_kind_e'(shift_kind);
    assign amt       = amount_in[AMT_W-1:0];
    assign unused_hi = ^amount_in[AREG_W-1:AMT_W];
    assign is_left   = (kind == SHK_LSL);

    for (genvar i = 0; i < W; i++) begin : g_rev
        assign rev_d[i]   = data_in[W-1-i];
        assign rev_res[i] = b_res[W-1-i];
    end

    assign b_in = is_left ? rev_d : data_in;

    shc_amt_decode #(.W(W), .AMT_W(AMT_W)) u_dec (
        .amt (amt),
        .cls (cls)
    );

    shc_barrel #(.W(W)) u_bar (
        .data     (b_in),
        .amt      (amt[SW-1:0]),
        .rotate   (kind == SHK_ROR),
        .fill     ((kind == SHK_ASR) && data_in[W-1]),
        .result   (b_res),
        .last_out (b_last)
    );

    // Undo the reversal for left shifts; rotate carry is the new MSB.
    always_comb begin
        sh_res   = is_left ? rev_res : b_res;
        sh_carry = (kind == SHK_ROR) ? b_res[W-1] : b_last;
    end

    shc_select #(.W(W)) u_sel (
        .kind     (kind),
        .cls      (cls),
        .data     (data_in),
        .cin      (carry_in),
        .sh_res   (sh_res),
        .sh_carry (sh_carry),
        .res      (result_out),
        .cout     (carry_out)
    );

    // Port-level checks of the boundary rules.
    always_comb begin
        if (!$isunknown({data_in, amount_in, shift_kind, carry_in})) begin
            if (amount_in[AMT_W-1:0] == '0) begin
                a_r2_zero_passthru: assert (result_out == data_in && carry_out == carry_in)
                    else $error("R2 zero distance altered outputs");
            end
            if (shift_kind == 2'b00 && amount_in[AMT_W-1:0] > AMT_W'(W)) begin
                a_r4_lsl_beyond: assert (result_out == '0 && carry_out == 1'b0)
                    else $error("R4 wide left shift not cleared");
            end
            if (shift_kind == 2'b01 && amount_in[AMT_W-1:0] > AMT_W'(W)) begin
                a_r6_lsr_beyond: assert (result_out == '0 && carry_out == 1'b0)
                    else $error("R6 wide right shift not cleared");
            end
            if (shift_kind == 2'b10 && amount_in[AMT_W-1:0] >= AMT_W'(W)) begin
                a_r8_asr_sign: assert (result_out == {W{data_in[W-1]}} && carry_out == data_in[W-1])
                    else $error("R8 wide arithmetic shift not sign filled");
            end
            if (shift_kind == 2'b11 && amount_in[AMT_W-1:0] != '0
                && amount_in[SW-1:0] == '0) begin
                a_r10_ror_wrap: assert (result_out == data_in && carry_out == data_in[W-1])
                    else $error("R10 wrapped rotate changed data");
            end
            if (shift_kind == 2'b11 && amount_in[SW-1:0] != '0) begin
                a_r9_ror_carry_msb: assert (carry_out == result_out[W-1])
                    else $error("R9 rotate carry differs from result MSB");
            end
        end
    end

endmodule

// File: tb/regshift_carry_tb.sv
// Sweeps all distances per operation against a behavioural model.
module regshift_carry_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] data_in = '0;
    logic [31:0] amount_in = '0;
    logic [1:0]  shift_kind = '0;
    logic        carry_in = 1'b0;
    logic [31:0] result_out;
    logic        carry_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    regshift_carry u_dut (
        .data_in    (data_in),
        .amount_in  (amount_in),
        .shift_kind (shift_kind),
        .carry_in   (carry_in),
        .result_out (result_out),
        .carry_out  (carry_out)
    );

    function automatic void model(input logic [31:0] d, input logic [31:0] a,
                                  input logic [1:0] k, input logic c,
                                  output logic [31:0] r, output logic co);
        int n;
        int m;
        n = int'(a[7:0]);
        m = n % 32;
        r = d; co = c;
        if (n != 0) begin
            case (k)
                2'd0: begin
                    if (n < 32)       begin r = d << n; co = d[32-n]; end
                    else if (n == 32) begin r = 0;      co = d[0];    end
                    else              begin r = 0;      co = 1'b0;    end
                end
                2'd1: begin
                    if (n < 32)       begin r = d >> n; co = d[n-1]; end
                    else if (n == 32) begin r = 0;      co = d[31];  end
                    else              begin r = 0;      co = 1'b0;   end
                end
                2'd2: begin
                    if (n < 32) begin r = $unsigned($signed(d) >>> n); co = d[n-1]; end
                    else        begin r = {32{d[31]}}; co = d[31]; end
                end
                default: begin
                    if (m == 0) begin r = d; co = d[31]; end
                    else begin r = (d >> m) | (d << (32 - m)); co = d[m-1]; end
                end
            endcase
        end
    endfunction

    function automatic string tag_of(input logic [1:0] k, input int n);
        if (n == 0) return "R2";
        case (k)
            2'd0:    return (n < 32) ? "R3" : "R4";
            2'd1:    return (n < 32) ? "R5" : "R6";
            2'd2:    return (n < 32) ? "R7" : "R8";
            default: return (n % 32 != 0) ? "R9" : "R10";
        endcase
    endfunction

    task automatic apply_check(input logic [31:0] d, input logic [31:0] a,
                               input logic [1:0] k, input logic c, input string tag);
        logic [31:0] er;
        logic        ec;
        @(posedge clk);
        data_in = d; amount_in = a; shift_kind = k; carry_in = c;
        @(negedge clk);
        model(d, a, k, c, er, ec);
        n_checks++;
        if (result_out !== er || carry_out !== ec) begin
            n_fail++;
            $display("FAIL %s kind=%0d amt=%h data=%h cin=%b: got res=%h c=%b exp res=%h c=%b",
                     tag, k, a, d, c, result_out, carry_out, er, ec);
        end
    endtask

    initial begin : main
        logic [31:0] words [8];
        words[0] = 32'h0000_0000; words[1] = 32'hFFFF_FFFF;
        words[2] = 32'h8000_0000; words[3] = 32'h0000_0001;
        words[4] = 32'h7FFF_FFFF; words[5] = 32'hA5C3_1E69;
        words[6] = $urandom;      words[7] = $urandom;

        // Reset-time state: all-zero inputs give zero word, carry held (R2).
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (result_out !== 32'h0 || carry_out !== 1'b0) begin
            n_fail++;
            $display("FAIL R2 reset state: got res=%h c=%b exp res=0 c=0", result_out, carry_out);
        end
        rst_n = 1'b1;

        // Full sweep of distances per operation (R2..R10).
        for (int k = 0; k < 4; k++) begin
            for (int n = 0; n < 256; n++) begin
                for (int w = 0; w < 8; w++) begin
                    apply_check(words[w], 32'(n), 2'(k), 1'((n + w) & 1),
                                tag_of(2'(k), n));
                end
            end
        end

        // Upper amount bits must be ignored (R1).
        for (int i = 0; i < 512; i++) begin
            logic [31:0] a;
            a = $urandom;
            if (a[31:8] == 0) a[31] = 1'b1;
            if (i < 16) a[7:0] = 8'(i * 16);
            apply_check($urandom, a, 2'(i & 3), 1'(i >> 2), "R1");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired before sweep completed");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule